// File: doc/BRIEF.md
# Serial PCM Codec Data Port

This block is the serial side of a voice-band codec. It exchanges 16-bit words with a host over four wires: a bit clock, a frame strobe, a serial input and a serial output. Each frame carries one outgoing A/D sample, or a status word, out of an output shift register, and one incoming word into an input shift register. Sixteen bit clocks after the frame starts, the incoming word is committed either to the D/A sample output or to a small control register. A target select sampled at the start of the frame chooses which.

Two mode pins set the port up. With the multiprocessor select low, the direction pin decides whether the frame strobe comes from outside or is generated in the block with a programmable frame length. With the multiprocessor select high, the port shares one data line with a second device in a two-slot time-division frame. The direction pin then picks the slot the port transmits in, and the port receives in the other slot. The whole block runs on the rising edge of the bit clock and has an asynchronous active-low reset.

The A/D side is a valid/ready stream into a one-word holding register. `adc_ready` is high while that register is empty. An accepted word waits there until a data frame loads it into the shifter, which empties the register. Nothing can push back on the D/A side: `dac_valid` is a one-cycle strobe that the consumer must take when it appears. The serial frame never stalls, so a frame that finds the holding register empty sends the previous sample again.

Top module: `pcm_codec_port`

## Requirements
- R1: `sdi` is sampled on rising edges E0..E15, MSB first, where E0 is the edge that detects the frame start. On edge E16 the word appears on `dac_data` with `dac_valid` high for exactly one cycle, provided the frame's target is the D/A side (`ctl_sel` low at E0).
- R2: After edge E0, `sdo` shows bit 15 of the word loaded into the output shifter. After each later edge Ek (k = 1..15), it shows bit 15-k.
- R3: A frame starts on a rising edge that samples the strobe low when the previous edge sampled it high. A strobe held low starts no second frame, and the commit still happens exactly once.
- R4: When `ctl_sel` is high at E0, bits 3..0 of the received word go to `ctl_bits` and `dac_valid` stays low. All 16 output bits equal `stat_flag`, and the held A/D sample is not consumed.
- R5: `word_rdy` is high for one cycle after every commit, whether the word goes to the D/A side or to the control register, and is low at all other times.
- R6: `adc_ready` is high exactly when the holding register is empty. An accepted word sets it low, and a data frame's load empties it. A data frame that finds the register empty sends the last loaded sample again.
- R7: With `mp_en`=0 and `dir_sel`=1, `strb_oe` is 1 and `strb_o` is low for one cycle every max(`frame_len`, 16) cycles. A generated strobe starts frames the same way an external one does. In every other mode `strb_oe` is 0.
- R8: With `mp_en`=1 and `dir_sel`=0, the port transmits after E0..E15, receives on E16..E31 and commits on E32. With `dir_sel`=1 it transmits after E16..E31, receives on E0..E15 and commits on E16. In this mode `sdo_oe` is 1 only during the port's own transmit slot.
- R9: While `rst_n` is low, `ctl_bits` equals the reset value 4'h8 and `dac_valid`, `word_rdy` and `sdo` are 0, with no clock needed. The holding register is empty, so `adc_ready` is 1.
- R10: With `mp_en`=0, `sdo_oe` is always 1 and `sdo` is 0 outside the 16-bit transmit window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mp_en | input | 1 | Two-slot multiprocessor mode select |
| dir_sel | input | 1 | Strobe direction (mp_en=0) or slot select (mp_en=1) |
| ctl_sel | input | 1 | Frame target, sampled at frame start: 1 = control register |
| stat_flag | input | 1 | Status flag sent in control frames |
| frame_len | input | 8 | Generated frame length in bit clocks (minimum 16) |
| strb_i | input | 1 | Frame strobe from outside, active falling |
| strb_o | output | 1 | Generated frame strobe |
| strb_oe | output | 1 | Output enable for the strobe pad |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data pad |
| adc_valid | input | 1 | A/D sample offered |
| adc_ready | output | 1 | Holding register empty |
| adc_data | input | 16 | A/D sample |
| dac_valid | output | 1 | D/A sample committed (one cycle) |
| dac_data | output | 16 | Last committed D/A sample |
| ctl_bits | output | 4 | Control register |
| word_rdy | output | 1 | Any word committed (one cycle) |

## Verification
Each result is tied to a fixed edge, counted from E0, the edge that samples the falling strobe. Output bit k is due at the sample after edge E(slot base + k). The commit pulse and its data are due at the sample after E16 in normal mode, and after E16 or E32 in two-slot mode, depending on the slot. A generated strobe goes low again `max(frame_len,16)` samples after its last low sample. The bench drives inputs just after the falling clock edge and samples outputs at the next falling edge. That edge follows exactly one rising edge, so each check lands on the cycle counted for it. The bench also checks `word_rdy` low on every other sample of a frame, which catches a commit that arrives early or late.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  // Operating modes decoded from the two mode pins.
  typedef enum logic [1:0] {
    MODE_EXT_STRB = 2'd0,  // frame strobe is an input
    MODE_GEN_STRB = 2'd1,  // frame strobe generated locally
    MODE_SLOT_LO  = 2'd2,  // shared line, transmit in first slot
    MODE_SLOT_HI  = 2'd3   // shared line, transmit in second slot
  } port_mode_e;

  function automatic port_mode_e decode_mode(input logic mp, input logic dir);
    if (mp) return dir ? MODE_SLOT_HI : MODE_SLOT_LO;
    else    return dir ? MODE_GEN_STRB : MODE_EXT_STRB;
  endfunction

endpackage

// File: rtl/pcm_strobe_gen.sv
module pcm_strobe_gen #(
  parameter int WORD_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LEN_W-1:0] frame_len,
  output logic             strb
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(WORD_W);

  logic [LEN_W-1:0] len_eff;
  logic [LEN_W-1:0] cnt;

  // Frames shorter than one word are stretched to one word.
  assign len_eff = (frame_len < MIN_LEN) ? MIN_LEN : frame_len;
  assign strb    = !(en && (cnt == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= LEN_W'(1);
    end else if (!en) begin
      cnt <= LEN_W'(1);
    end else if (cnt >= len_eff - LEN_W'(1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + LEN_W'(1);
    end
  end
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_port_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strb,
  input  port_mode_e mode,
  output logic       frame_start,
  output logic       tx_load,
  output logic       tx_shift,
  output logic       rx_shift,
  output logic       commit,
  output logic       in_tx
);
  localparam int CYC_W = $clog2(2 * WORD_W + 1);
  localparam logic [CYC_W-1:0] W = CYC_W'(WORD_W);

  logic             strb_q;
  logic             act;
  logic [CYC_W-1:0] cyc;
  logic [CYC_W-1:0] tx_base, rx_base, last;
  logic [CYC_W-1:0] nxt, idx;
  logic             running, live;

  // Slot layout per mode: transmit base, receive base, last edge index.
  always_comb begin
    tx_base = '0;
    rx_base = '0;
    last    = W;
    case (mode)
      MODE_EXT_STRB, MODE_GEN_STRB: begin
        tx_base = '0;
        rx_base = '0;
        last    = W;
      end
      MODE_SLOT_LO: begin
        tx_base = '0;
        rx_base = W;
        last    = W + W;
      end
      MODE_SLOT_HI: begin
        tx_base = W;
        rx_base = '0;
        last    = W + W;
      end
      default: ;
    endcase
  end

  assign frame_start = strb_q && !strb;
  assign nxt         = cyc + 1'b1;
  assign running     = act && (cyc < last);
  assign live        = frame_start || running;
  assign idx         = frame_start ? '0 : nxt;

  assign tx_load  = live && (idx == tx_base);
  assign tx_shift = live && (idx > tx_base) && (idx < tx_base + W);
  assign rx_shift = live && (idx >= rx_base) && (idx < rx_base + W);
  // A commit due on the same edge as a new start still takes place.
  assign commit   = running && (nxt == rx_base + W);
  assign in_tx    = act && (cyc >= tx_base) && (cyc < tx_base + W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b1;
      act    <= 1'b0;
      cyc    <= '0;
    end else begin
      strb_q <= strb;
      if (frame_start) begin
        act <= 1'b1;
        cyc <= '0;
      end else if (running) begin
        cyc <= nxt;
      end else begin
        act <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_valid,
  input  logic [WORD_W-1:0] adc_data,
  output logic              adc_ready,
  input  logic              load,
  input  logic              shift,
  input  logic              use_stat,
  input  logic              stat,
  input  logic              in_tx,
  output logic              sdo
);
  logic [WORD_W-1:0] hold;
  logic              full;
  logic [WORD_W-1:0] osr;

  assign adc_ready = !full;
  assign sdo       = in_tx & osr[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      full <= 1'b0;
      osr  <= '0;
    end else begin
      if (load) begin
        osr <= use_stat ? {WORD_W{stat}} : hold;
        if (!use_stat) full <= 1'b0;
      end else if (shift) begin
        osr <= {osr[WORD_W-2:0], 1'b0};
      end
      // Acceptance only while empty; wins over a load in the same cycle.
      if (adc_valid && !full) begin
        hold <= adc_data;
        full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path #(
  parameter int                WORD_W  = 16,
  parameter int                CTL_W   = 4,
  parameter logic [CTL_W-1:0]  CTL_RST = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              shift,
  input  logic              commit,
  input  logic              to_ctl,
  output logic              dac_valid,
  output logic [WORD_W-1:0] dac_data,
  output logic [CTL_W-1:0]  ctl_bits,
  output logic              word_rdy
);
  logic [WORD_W-1:0] isr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr       <= '0;
      dac_valid <= 1'b0;
      dac_data  <= '0;
      ctl_bits  <= CTL_RST;
      word_rdy  <= 1'b0;
    end else begin
      if (shift) isr <= {isr[WORD_W-2:0], sdi};
      word_rdy  <= commit;
      dac_valid <= commit && !to_ctl;
      if (commit) begin
        if (to_ctl) ctl_bits <= isr[CTL_W-1:0];
        else        dac_data <= isr;
      end
    end
  end
endmodule

// File: rtl/pcm_codec_port.sv
module pcm_codec_port
  import pcm_port_pkg::*;
#(
  parameter int               WORD_W  = 16,
  parameter int               CTL_W   = 4,
  parameter int               LEN_W   = 8,
  parameter logic [CTL_W-1:0] CTL_RST = 4'h8
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              mp_en,
  input  logic              dir_sel,
  input  logic              ctl_sel,
  input  logic              stat_flag,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              strb_i,
  output logic              strb_o,
  output logic              strb_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              adc_valid,
  output logic              adc_ready,
  input  logic [WORD_W-1:0] adc_data,
  output logic              dac_valid,
  output logic [WORD_W-1:0] dac_data,
  output logic [CTL_W-1:0]  ctl_bits,
  output logic              word_rdy
);
  port_mode_e mode;
  logic       gen_en, shared;
  logic       strb_int;
  logic       frame_start, tx_load, tx_shift, rx_shift, commit, in_tx;
  logic       tgt_q, tgt_now;

  assign mode     = decode_mode(mp_en, dir_sel);
  assign gen_en   = (mode == MODE_GEN_STRB);
  assign shared   = (mode == MODE_SLOT_LO) || (mode == MODE_SLOT_HI);
  assign strb_oe  = gen_en;
  assign strb_int = gen_en ? strb_o : strb_i;
  assign sdo_oe   = shared ? in_tx : 1'b1;
  assign tgt_now  = frame_start ? ctl_sel : tgt_q;

  // Frame target is latched at the start edge.
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n)           tgt_q <= 1'b0;
    else if (frame_start) tgt_q <= ctl_sel;
  end

  pcm_strobe_gen #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_strb (
    .clk       (bclk),
    .rst_n     (rst_n),
    .en        (gen_en),
    .frame_len (frame_len),
    .strb      (strb_o)
  );

  pcm_frame_timer #(.WORD_W(WORD_W)) u_timer (
    .clk         (bclk),
    .rst_n       (rst_n),
    .strb        (strb_int),
    .mode        (mode),
    .frame_start (frame_start),
    .tx_load     (tx_load),
    .tx_shift    (tx_shift),
    .rx_shift    (rx_shift),
    .commit      (commit),
    .in_tx       (in_tx)
  );

  pcm_tx_path #(.WORD_W(WORD_W)) u_tx (
    .clk       (bclk),
    .rst_n     (rst_n),
    .adc_valid (adc_valid),
    .adc_data  (adc_data),
    .adc_ready (adc_ready),
    .load      (tx_load),
    .shift     (tx_shift),
    .use_stat  (tgt_now),
    .stat      (stat_flag),
    .in_tx     (in_tx),
    .sdo       (sdo)
  );

  pcm_rx_path #(.WORD_W(WORD_W), .CTL_W(CTL_W), .CTL_RST(CTL_RST)) u_rx (
    .clk       (bclk),
    .rst_n     (rst_n),
    .sdi       (sdi),
    .shift     (rx_shift),
    .commit    (commit),
    .to_ctl    (tgt_q),
    .dac_valid (dac_valid),
    .dac_data  (dac_data),
    .ctl_bits  (ctl_bits),
    .word_rdy  (word_rdy)
  );
endmodule

// File: rtl/pcm_codec_port_chk.sv
module pcm_codec_port_chk #(
  parameter int CTL_W = 4
) (
  input logic             bclk,
  input logic             rst_n,
  input logic             strb_o,
  input logic             strb_oe,
  input logic             adc_valid,
  input logic             adc_ready,
  input logic             dac_valid,
  input logic             word_rdy,
  input logic [CTL_W-1:0] ctl_bits,
  input logic             sdo,
  input logic             sdo_oe
);
  // R5: commit flag never lasts two cycles.
  a_r5_rdy_single: assert property (@(posedge bclk) disable iff (!rst_n)
    word_rdy |=> !word_rdy);

  // R1: a D/A strobe is always part of a commit.
  a_r1_dac_in_commit: assert property (@(posedge bclk) disable iff (!rst_n)
    dac_valid |-> word_rdy);

  // R6: an accepted sample closes the stream until it is consumed.
  a_r6_accept_blocks: assert property (@(posedge bclk) disable iff (!rst_n)
    (adc_valid && adc_ready) |=> !adc_ready);

  // R7: a generated strobe is low for a single bit clock.
  a_r7_strobe_short: assert property (@(posedge bclk) disable iff (!rst_n)
    (strb_oe && !strb_o) |=> strb_o);

  // R4: the control register moves only together with a commit.
  a_r4_ctl_on_commit: assert property (@(posedge bclk) disable iff (!rst_n)
    !$stable(ctl_bits) |-> word_rdy);

  // R10: an undriven data pad carries no data.
  a_r10_idle_low: assert property (@(posedge bclk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
endmodule

bind pcm_codec_port pcm_codec_port_chk #(.CTL_W(CTL_W)) u_chk (
  .bclk      (bclk),
  .rst_n     (rst_n),
  .strb_o    (strb_o),
  .strb_oe   (strb_oe),
  .adc_valid (adc_valid),
  .adc_ready (adc_ready),
  .dac_valid (dac_valid),
  .word_rdy  (word_rdy),
  .ctl_bits  (ctl_bits),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe)
);

// File: tb/pcm_codec_port_bench.sv
`timescale 1ns/1ps
module pcm_codec_port_bench;
  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mp_en = 1'b0, dir_sel = 1'b0, ctl_sel = 1'b0, stat_flag = 1'b0;
  logic [7:0]  frame_len = 8'd20;
  logic        strb_i = 1'b1;
  logic        strb_o, strb_oe;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe;
  logic        adc_valid = 1'b0;
  logic        adc_ready;
  logic [15:0] adc_data = '0;
  logic        dac_valid;
  logic [15:0] dac_data;
  logic [3:0]  ctl_bits;
  logic        word_rdy;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  logic [15:0] mdl_hold = '0;
  bit          mdl_full = 0;

  always #2.5 bclk = ~bclk;

  pcm_codec_port u_pcm_codec_port (
    .bclk(bclk), .rst_n(rst_n), .mp_en(mp_en), .dir_sel(dir_sel),
    .ctl_sel(ctl_sel), .stat_flag(stat_flag), .frame_len(frame_len),
    .strb_i(strb_i), .strb_o(strb_o), .strb_oe(strb_oe), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .adc_valid(adc_valid), .adc_ready(adc_ready),
    .adc_data(adc_data), .dac_valid(dac_valid), .dac_data(dac_data),
    .ctl_bits(ctl_bits), .word_rdy(word_rdy)
  );

  typedef struct packed {
    logic        push;
    logic        mp;
    logic        dir;
    logic        ctl;
    logic        stat;
    logic [15:0] adc;
    logic [15:0] din;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3, 16'h1234},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8001, 16'hFFFF},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0F0F, 16'h0006},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7777, 16'h8000},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h3C5A, 16'h5AA5},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'hC001, 16'h0FF0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h1111, 16'h0003},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2222, 16'h0001},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h9999, 16'h4321}
  };

  task automatic step();
    @(posedge bclk);
    @(negedge bclk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_adc(input logic [15:0] d);
    chk(adc_ready == 1'b1, "R6 ready while empty", 32'(adc_ready), 32'd1);
    adc_valid = 1'b1;
    adc_data  = d;
    step();
    adc_valid = 1'b0;
    chk(adc_ready == 1'b0, "R6 ready low once full", 32'(adc_ready), 32'd0);
    mdl_hold = d;
    mdl_full = 1;
  endtask

  task automatic run_frame(input vec_t v);
    int t, r, last;
    logic [15:0] txw;
    if (v.push && !mdl_full) push_adc(v.adc);
    txw = v.ctl ? {16{v.stat}} : mdl_hold;
    if (!v.ctl) mdl_full = 0;
    t    = (v.mp && v.dir) ? 16 : 0;
    r    = (v.mp && !v.dir) ? 16 : 0;
    last = v.mp ? 32 : 16;
    mp_en = v.mp; dir_sel = v.dir; ctl_sel = v.ctl; stat_flag = v.stat;
    strb_i = 1'b1;
    step();
    for (int e = 0; e <= last + 1; e++) begin
      strb_i = (e == 0) ? 1'b0 : 1'b1;
      sdi    = (e >= r && e < r + 16) ? v.din[15 - (e - r)] : 1'b0;
      step();
      if (e >= t && e < t + 16) begin
        chk(sdo == txw[15 - (e - t)], "R2 serial out bit", 32'(sdo),
            32'(txw[15 - (e - t)]));
        chk(sdo_oe == 1'b1, "R8 driver on in own slot", 32'(sdo_oe), 32'd1);
      end else if (v.mp) begin
        chk(sdo_oe == 1'b0, "R8 driver off outside slot", 32'(sdo_oe), 32'd0);
      end else begin
        chk(sdo == 1'b0 && sdo_oe == 1'b1, "R10 quiet outside word",
            {30'd0, sdo_oe, sdo}, 32'd2);
      end
      if (e == r + 16) begin
        chk(word_rdy == 1'b1, "R5 commit flag", 32'(word_rdy), 32'd1);
        if (v.ctl) begin
          chk(ctl_bits == v.din[3:0], "R4 control bits", 32'(ctl_bits),
              32'(v.din[3:0]));
          chk(dac_valid == 1'b0, "R4 no D/A strobe", 32'(dac_valid), 32'd0);
        end else begin
          chk(dac_valid == 1'b1 && dac_data == v.din, "R1 D/A word",
              {15'd0, dac_valid, dac_data}, {15'd0, 1'b1, v.din});
        end
      end else begin
        chk(word_rdy == 1'b0, "R5 flag idle", 32'(word_rdy), 32'd0);
      end
    end
    if (v.ctl) chk(adc_ready == 1'b0, "R4 sample kept", 32'(adc_ready), 32'd0);
    else       chk(adc_ready == 1'b1, "R6 sample consumed", 32'(adc_ready), 32'd1);
  endtask

  task automatic gen_check(input logic [7:0] len);
    int lim, eff;
    bit seen;
    eff = (len < 8'd16) ? 16 : int'(len);
    mp_en = 1'b0; dir_sel = 1'b0; sdi = 1'b1;
    step();
    frame_len = len;
    dir_sel = 1'b1;
    seen = 0;
    for (int i = 0; i < 64 && !seen; i++) begin
      step();
      if (strb_o == 1'b0) seen = 1;
    end
    chk(seen && strb_oe == 1'b1, "R7 strobe generated", {30'd0, strb_oe, seen}, 32'd3);
    lim = (eff > 17) ? eff : 17;
    for (int n = 1; n <= lim; n++) begin
      step();
      chk(strb_o == (n != eff), "R7 strobe period", 32'(strb_o), 32'(n != eff));
      if (n == 17)
        chk(word_rdy && dac_valid && dac_data == 16'hFFFF, "R7 frame from own strobe",
            32'(dac_data), 32'hFFFF);
    end
    dir_sel = 1'b0; sdi = 1'b0;
    step();
    chk(strb_oe == 1'b0, "R7 strobe released", 32'(strb_oe), 32'd0);
    step(); step();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge bclk);
    // R9: values held in reset
    chk(ctl_bits == 4'h8, "R9 control default", 32'(ctl_bits), 32'h8);
    chk(!dac_valid && !word_rdy && !sdo, "R9 outputs quiet",
        {29'd0, dac_valid, word_rdy, sdo}, 32'd0);
    chk(adc_ready == 1'b1, "R9 holding empty", 32'(adc_ready), 32'd1);
    step();
    rst_n = 1'b1;
    step();
    chk(sdo_oe == 1'b1 && strb_oe == 1'b0, "R10 normal mode drives",
        {30'd0, sdo_oe, strb_oe}, 32'd2);

    for (int i = 0; i < NV; i++) run_frame(VECS[i]);

    // R3: strobe held low gives one frame and one commit
    mp_en = 1'b0; dir_sel = 1'b0; ctl_sel = 1'b0;
    step();
    for (int e = 0; e <= 22; e++) begin
      strb_i = 1'b0;
      sdi    = (e < 16) ? 16'hBEEF >> (15 - e) : 1'b0;
      step();
      if (e == 16)
        chk(word_rdy && dac_data == 16'hBEEF, "R3 single frame commit",
            32'(dac_data), 32'hBEEF);
      else
        chk(word_rdy == 1'b0, "R3 no second frame", 32'(word_rdy), 32'd0);
    end
    strb_i = 1'b1;
    mdl_full = 0;
    step();

    // R7: generated strobe, normal length and clamped length
    gen_check(8'd20);
    gen_check(8'd5);

    // R9: asynchronous reset mid-frame restores the control register
    run_frame('{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h5555, 16'h000B});
    chk(ctl_bits == 4'hB, "R4 control before reset", 32'(ctl_bits), 32'hB);
    strb_i = 1'b0;
    step();
    strb_i = 1'b1;
    step();
    #1 rst_n = 1'b0;
    #1;
    chk(ctl_bits == 4'h8, "R9 async control default", 32'(ctl_bits), 32'h8);
    chk(adc_ready && !dac_valid && !word_rdy, "R9 async outputs",
        {29'd0, adc_ready, dac_valid, word_rdy}, 32'd4);
    @(negedge bclk);
    rst_n = 1'b1;
    step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule